// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block keeps a small set of recent virtual-page to physical-page mappings in front of a page table walker. A requester presents a 32-bit virtual address and an access kind. When a stored mapping matches, the block returns the physical address and a permission verdict in the same cycle. When no mapping matches, it asserts a refill request carrying the virtual page number. The walker answers with a fill entry, and the requester repeats the same lookup, which then hits.

Every entry holds a page tag, a physical page number and five flags: valid, readable, writable, executable and dirty. Entries are only a copy of the page tables. They are never written back, so writes to memory-resident tables go through the walker. Changing the page-table base flushes everything. A targeted invalidate removes the one mapping for a named virtual page. Replacement fills free slots first. When no slot is free, it evicts the least recently used entry.

Top module: `tlb_fa`

## Requirements
- R1: After reset every entry is invalid, so any lookup reports no hit and raises a refill request.
- R2: A lookup compares bits [31:12] of `lk_vaddr` with the tag of every valid entry in parallel. `lk_hit` is combinational and is valid in the same cycle.
- R3: On a hit, `lk_paddr` is the entry's physical page number in bits [31:12] and `lk_vaddr[11:0]` in bits [11:0].
- R4: `lk_kind` uses the codes 0 = read, 1 = write, 2 = execute and 3 = reserved. `lk_perm_ok` is high only on a hit whose entry grants the requested kind; the reserved code is never granted. A hit that lacks the permission still reports `lk_hit` = 1.
- R5: `refill_req` equals `lk_valid` and not `lk_hit`. `refill_vpn` carries bits [31:12] of `lk_vaddr`.
- R6: A write lookup that matches an entry whose dirty flag is 0 reports a miss and a refill request.
- R7: A fill is installed at the clock edge, and the same lookup hits from the next cycle onward. A fill whose page is already cached overwrites that entry, so no duplicate tag is ever created.
- R8: A fill for a new page goes to the lowest-numbered invalid entry. If there is none, it goes to the least recently used entry, which then stops hitting.
- R9: Recency is refreshed by every lookup hit and by every fill, and the fill takes precedence when both happen in one cycle. After reset, the least recent entry is the highest-numbered one.
- R10: `base_wr` invalidates all entries at the next edge. A fill in the same cycle is discarded.
- R11: `inv_valid` invalidates the entry whose tag equals `inv_vpn`. A fill of that same page in the same cycle is discarded. Other entries are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| lk_hit | output | 1 | Usable mapping found |
| lk_paddr | output | 32 | Translated physical address |
| lk_perm_ok | output | 1 | Hit and the access is permitted |
| refill_req | output | 1 | Lookup missed; walk required |
| refill_vpn | output | 20 | Virtual page to walk |
| fill_valid | input | 1 | Walker delivers an entry |
| fill_vpn | input | 20 | Tag of delivered entry |
| fill_ppn | input | 20 | Physical page of delivered entry |
| fill_rd | input | 1 | Read permission |
| fill_wr | input | 1 | Write permission |
| fill_ex | input | 1 | Execute permission |
| fill_dirty | input | 1 | Page already marked modified |
| base_wr | input | 1 | Page-table base written: flush all |
| inv_valid | input | 1 | Invalidate one page |
| inv_vpn | input | 20 | Page to invalidate |

## Verification
The lookup results (`lk_hit`, `lk_paddr`, `lk_perm_ok`, `refill_req`, `refill_vpn`) are combinational. They are due in the same cycle as the address, so the bench drives inputs on the falling edge and samples one time unit later, before the next rising edge. A fill, flush or invalidate changes the stored state at the following rising edge. Its effect is therefore due in the next cycle's lookup, and the bench's reference model applies each update only after that edge. The model keeps its recency order as a queue and compares every output on every cycle. This makes evictions, touches and the flush and invalidate priorities all visible as hits or misses at the ports.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W  = 32;
  localparam int OFS_W = 12;
  localparam int VPN_W = VA_W - OFS_W;
  localparam int PPN_W = 20;
  localparam int PA_W  = PPN_W + OFS_W;

  typedef enum logic [1:0] {ACC_RD = 2'd0, ACC_WR = 2'd1, ACC_EX = 2'd2, ACC_RSV = 2'd3} acc_t;

  typedef struct packed {
    logic             vld;
    logic             rd;
    logic             wr;
    logic             ex;
    logic             dty;
    logic [VPN_W-1:0] vpn;
    logic [PPN_W-1:0] ppn;
  } xlat_ent_t;

  function automatic logic [PA_W-1:0] join_paddr(input logic [PPN_W-1:0] ppn,
                                                 input logic [OFS_W-1:0] ofs);
    return {ppn, ofs};
  endfunction

  function automatic logic perm_grant(input acc_t kind, input xlat_ent_t e);
    case (kind)
      ACC_RD:  return e.rd;
      ACC_WR:  return e.wr;
      ACC_EX:  return e.ex;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam import tlb_pkg::*; #(
  parameter int N = 16
) (
  input  xlat_ent_t        ent [N],
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [VPN_W-1:0] fl_vpn,
  output logic [N-1:0]     lk_match,
  output logic [N-1:0]     fl_match
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign lk_match[g] = ent[g].vld && (ent[g].vpn == lk_vpn);
    assign fl_match[g] = ent[g].vld && (ent[g].vpn == fl_vpn);
  end

  // R2
  always_comb begin
    tag_unique_chk: assert ($onehot0(lk_match) || $isunknown(lk_match));
  end
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int N  = 16,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch_en,
  input  logic [IW-1:0] touch_idx,
  output logic [IW-1:0] victim_idx
);
  logic [IW-1:0] age [N];
  logic [N-1:0]  oldest_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age[i] <= IW'(i);
    end else if (touch_en) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == touch_idx)          age[i] <= '0;
        else if (age[i] < age[touch_idx]) age[i] <= age[i] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_idx = '0;
    for (int i = 0; i < N; i++) begin
      oldest_vec[i] = (age[i] == IW'(N-1));
      if (oldest_vec[i]) victim_idx = IW'(i);
    end
  end

  // R9
  oldest_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest_vec) == 1);
  // R9
  touched_newest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> age[$past(touch_idx)] == '0);
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa import tlb_pkg::*; #(
  parameter int ENTRIES = 16,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic [1:0]        lk_kind,
  output logic              lk_hit,
  output logic [PA_W-1:0]   lk_paddr,
  output logic              lk_perm_ok,
  output logic              refill_req,
  output logic [VPN_W-1:0]  refill_vpn,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic              fill_rd,
  input  logic              fill_wr,
  input  logic              fill_ex,
  input  logic              fill_dirty,
  input  logic              base_wr,
  input  logic              inv_valid,
  input  logic [VPN_W-1:0]  inv_vpn
);
  xlat_ent_t         ent [ENTRIES];
  logic [ENTRIES-1:0] lk_match, fl_match, inv_match, free_vec;
  logic [VPN_W-1:0]   lk_vpn;
  logic [IW-1:0]      sel_idx, fill_idx, free_idx, victim_idx, touch_idx;
  logic               tag_hit, dirty_block, fill_take, touch_en;
  xlat_ent_t          sel;
  acc_t               kind;

  assign lk_vpn = lk_vaddr[VA_W-1:OFS_W];
  assign kind   = acc_t'(lk_kind);

  tlb_cam #(.N(ENTRIES)) cam_i (
    .ent(ent), .lk_vpn(lk_vpn), .fl_vpn(fill_vpn),
    .lk_match(lk_match), .fl_match(fl_match));

  tlb_cam #(.N(ENTRIES)) inv_cam_i (
    .ent(ent), .lk_vpn(inv_vpn), .fl_vpn(inv_vpn),
    .lk_match(inv_match), .fl_match());

  always_comb begin
    sel_idx  = '0;
    free_idx = '0;
    fill_idx = '0;
    for (int i = ENTRIES-1; i >= 0; i--) begin
      free_vec[i] = !ent[i].vld;
      if (lk_match[i]) sel_idx  = IW'(i);
      if (free_vec[i]) free_idx = IW'(i);
      if (fl_match[i]) fill_idx = IW'(i);
    end
    if (!(|fl_match)) fill_idx = (|free_vec) ? free_idx : victim_idx;
  end

  assign tag_hit     = |lk_match;
  assign sel         = ent[sel_idx];
  assign dirty_block = (kind == ACC_WR) && !sel.dty;
  assign lk_hit      = lk_valid && tag_hit && !dirty_block;
  assign lk_paddr    = join_paddr(sel.ppn, lk_vaddr[OFS_W-1:0]);
  assign lk_perm_ok  = lk_hit && perm_grant(kind, sel);
  assign refill_req  = lk_valid && !lk_hit;
  assign refill_vpn  = lk_vpn;

  assign fill_take = fill_valid && !base_wr && !(inv_valid && inv_vpn == fill_vpn);
  assign touch_en  = fill_take || lk_hit;
  assign touch_idx = fill_take ? fill_idx : sel_idx;

  tlb_lru #(.N(ENTRIES)) lru_i (
    .clk(clk), .rst_n(rst_n), .touch_en(touch_en),
    .touch_idx(touch_idx), .victim_idx(victim_idx));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ent[i] <= '0;
    end else if (base_wr) begin
      for (int i = 0; i < ENTRIES; i++) ent[i].vld <= 1'b0;
    end else begin
      if (inv_valid)
        for (int i = 0; i < ENTRIES; i++)
          if (inv_match[i]) ent[i].vld <= 1'b0;
      if (fill_take)
        ent[fill_idx] <= '{vld: 1'b1, rd: fill_rd, wr: fill_wr, ex: fill_ex,
                           dty: fill_dirty, vpn: fill_vpn, ppn: fill_ppn};
    end
  end

  // R5
  miss_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_hit) |-> refill_req);
  // R6
  clean_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && kind == ACC_WR) |-> sel.dty);
  // R7
  fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_take |=> ent[$past(fill_idx)].vld && ent[$past(fill_idx)].vpn == $past(fill_vpn));
  // R10
  flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    base_wr |=> !ent[0].vld && !ent[ENTRIES-1].vld && !(|lk_match));
  // R11
  inv_gone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && !fill_take) |=> !(|inv_match) || inv_vpn != $past(inv_vpn));
endmodule

// File: tb/tlb_fa_tb.sv
module tlb_fa_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        lk_valid = 0;
  logic [31:0] lk_vaddr = '0;
  logic [1:0]  lk_kind = '0;
  logic        lk_hit, lk_perm_ok, refill_req;
  logic [31:0] lk_paddr;
  logic [19:0] refill_vpn;
  logic        fill_valid = 0, fill_rd = 0, fill_wr = 0, fill_ex = 0, fill_dirty = 0;
  logic [19:0] fill_vpn = '0, fill_ppn = '0, inv_vpn = '0;
  logic        base_wr = 0, inv_valid = 0;

  int checks = 0, errors = 0;
  bit done = 0;

  bit          m_v [N];
  bit          m_r [N], m_w [N], m_x [N], m_d [N];
  logic [19:0] m_vpn [N], m_ppn [N];
  int          recent [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_fa dut_i (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int find(input logic [19:0] v);
    for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == v) return i;
    return -1;
  endfunction

  task automatic touch(input int i);
    foreach (recent[k]) if (recent[k] == i) begin recent.delete(k); break; end
    recent.push_front(i);
  endtask

  // One cycle: compare combinational outputs, then advance the model past the edge.
  task automatic cyc();
    int idx, tgt;
    bit ehit, eperm, take;
    logic [31:0] epa;
    #1;
    idx   = find(lk_vaddr[31:12]);
    ehit  = lk_valid && idx >= 0 && !(lk_kind == 2'd1 && !m_d[idx]);
    eperm = ehit && ((lk_kind == 2'd0 && m_r[idx]) || (lk_kind == 2'd1 && m_w[idx]) ||
                     (lk_kind == 2'd2 && m_x[idx]));
    epa   = (idx >= 0) ? {m_ppn[idx], lk_vaddr[11:0]} : 32'h0;
    chk(lk_hit === ehit, "R2/R6 hit", lk_hit, ehit);
    chk(lk_perm_ok === eperm, "R4 perm", lk_perm_ok, eperm);
    chk(refill_req === (lk_valid && !ehit), "R5 refill_req", refill_req, lk_valid && !ehit);
    chk(refill_vpn === lk_vaddr[31:12], "R5 refill_vpn", refill_vpn, lk_vaddr[31:12]);
    if (ehit) chk(lk_paddr === epa, "R3 paddr", lk_paddr, epa);
    tgt = -1;
    take = fill_valid && !base_wr && !(inv_valid && inv_vpn == fill_vpn);
    if (take) begin
      tgt = find(fill_vpn);
      if (tgt < 0) for (int i = 0; i < N; i++) if (!m_v[i]) begin tgt = i; break; end
      if (tgt < 0) tgt = recent[$];
    end
    @(posedge clk);
    #1;
    if (base_wr) begin
      for (int i = 0; i < N; i++) m_v[i] = 0;
    end else begin
      if (inv_valid && find(inv_vpn) >= 0) m_v[find(inv_vpn)] = 0;
      if (take) begin
        m_v[tgt] = 1; m_vpn[tgt] = fill_vpn; m_ppn[tgt] = fill_ppn;
        m_r[tgt] = fill_rd; m_w[tgt] = fill_wr; m_x[tgt] = fill_ex; m_d[tgt] = fill_dirty;
      end
    end
    if (take) touch(tgt);
    else if (ehit) touch(idx);
    @(negedge clk);
  endtask

  task automatic idle();
    lk_valid = 0; fill_valid = 0; base_wr = 0; inv_valid = 0;
  endtask

  task automatic look(input logic [19:0] v, input logic [11:0] o, input logic [1:0] k);
    idle(); lk_valid = 1; lk_vaddr = {v, o}; lk_kind = k; cyc();
  endtask

  task automatic fill(input logic [19:0] v, input logic [19:0] p, input logic [3:0] rwxd);
    idle(); fill_valid = 1; fill_vpn = v; fill_ppn = p;
    {fill_rd, fill_wr, fill_ex, fill_dirty} = rwxd; cyc();
  endtask

  // Sample a lookup result at the ports for a named check.
  task automatic probe(input logic [19:0] v, input logic [1:0] k, input bit exp, input string tag);
    idle(); lk_valid = 1; lk_vaddr = {v, 12'h123}; lk_kind = k;
    #1 chk(lk_hit === exp, tag, lk_hit, exp);
    cyc();
  endtask

  initial begin
    for (int i = 0; i < N; i++) recent.push_back(i);
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: nothing hits after reset
    probe(20'h00000, 2'd0, 0, "R1 reset miss");
    probe(20'hABCDE, 2'd2, 0, "R1 reset miss");
    // R7 miss, fill, retry
    look(20'h7192A, 12'h44C, 2'd1);
    fill(20'h7192A, 20'h14817, 4'b1101);
    probe(20'h7192A, 2'd1, 1, "R7 retry hits");
    look(20'h7192A, 12'h44C, 2'd0);
    look(20'h7192A, 12'hFFF, 2'd2);
    look(20'h7192A, 12'h000, 2'd3);
    // R6 clean page write misses
    fill(20'h00042, 20'h00777, 4'b1100);
    probe(20'h00042, 2'd1, 0, "R6 clean write miss");
    probe(20'h00042, 2'd0, 1, "R6 clean read hit");
    fill(20'h00042, 20'h00777, 4'b1101);
    probe(20'h00042, 2'd1, 1, "R7 overwrite hits");
    // R8/R9 fill the rest, then evict by recency
    for (int i = 2; i < N; i++) fill(20'h10000 + 20'(i), 20'h20000 + 20'(i), 4'b1011);
    look(20'h7192A, 12'h010, 2'd0);
    fill(20'h30000, 20'h3FFFF, 4'b1111);
    probe(20'h00042, 2'd0, 0, "R8 lru victim evicted");
    probe(20'h7192A, 2'd0, 1, "R9 touched kept");
    probe(20'h30000, 2'd2, 1, "R8 new fill hits");
    // R11 targeted invalidate, and same-page fill dropped
    idle(); inv_valid = 1; inv_vpn = 20'h10005; cyc();
    probe(20'h10005, 2'd0, 0, "R11 invalidated");
    probe(20'h10006, 2'd0, 1, "R11 neighbour kept");
    idle(); inv_valid = 1; inv_vpn = 20'h50000; fill_valid = 1; fill_vpn = 20'h50000;
    fill_ppn = 20'h1; {fill_rd, fill_wr, fill_ex, fill_dirty} = 4'b1111; cyc();
    probe(20'h50000, 2'd0, 0, "R11 fill dropped");
    fill(20'h60000, 20'h6, 4'b1000);
    probe(20'h60000, 2'd0, 1, "R8 free slot reused");
    // R10 flush wins over same-cycle fill
    idle(); base_wr = 1; fill_valid = 1; fill_vpn = 20'h70000; fill_ppn = 20'h7;
    lk_valid = 1; lk_vaddr = {20'h30000, 12'h0}; lk_kind = 2'd0; cyc();
    probe(20'h70000, 2'd0, 0, "R10 fill discarded");
    probe(20'h30000, 2'd0, 0, "R10 flushed");
    probe(20'h7192A, 2'd0, 0, "R10 flushed");
    fill(20'h80000, 20'h8, 4'b1111);
    probe(20'h80000, 2'd1, 1, "R7 after flush");
    idle(); cyc();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule